// File: doc/BRIEF.md
# 1-Wire Register Access Sequencer

This block turns one register read or write request into the ordered list of byte operations that a register-style slave on a 1-Wire bus expects. It sits between a requester and a byte-level 1-Wire engine. The engine offers three operations: reset-and-select of the slave, which returns a success flag; sending one byte; and receiving one byte. The sequencer issues these one at a time and waits for each to finish before it starts the next.

A request carries a direction, a two-bit format code, an address and write data. The format code chooses the address width (8 or 16 bits) and the data width (8 or 16 bits). The sequencer first checks the request. If the request is well formed, it selects the slave, sends the read or write command byte, sends the address bytes least significant first, and then sends or receives the data bytes least significant first. When the transaction ends, a one-cycle done pulse returns a status code and, for reads, the assembled data.

Top module: `onewire_reg_sequencer`

## Requirements
- R1: Every accepted, well-formed request starts with a select operation (engine op code 0). If that operation completes with `eng_ok` low, the request ends with status 1 (no device) and no other engine operation is issued.
- R2: A read sends a write-byte operation (op code 1) carrying command 0x69 right after the select. The address bytes follow, and then one receive operation (op code 2) per data byte.
- R3: A write sends a write-byte operation carrying command 0x6C right after the select. The address bytes follow, and then one write-byte operation per data byte.
- R4: Multi-byte fields are sent least significant byte first. On a 16-bit read, the first received byte becomes `rsp_rdata[7:0]` and the second becomes `rsp_rdata[15:8]`.
- R5: Format bit 0 selects the address width. When it is 0, one address byte (`req_addr[7:0]`) is sent. When it is 1, two address bytes are sent.
- R6: Format bit 1 selects the data width. When it is 0, one data byte is moved and a read returns zero in `rsp_rdata[15:8]`. When it is 1, two data bytes are moved.
- R7: With a supported format, an address above 255 (8-bit address) or above 65535 (16-bit address) ends the request with status 2 (invalid argument) and no engine operation.
- R8: Format code 1 (16-bit address with 8-bit data) is unsupported. It ends the request with status 3 and no engine operation, whatever the address.
- R9: `req_ready` is high only while the block is idle. Each accepted request produces exactly one single-cycle `rsp_done` pulse, with status 0 on success, and the block is idle again in the next cycle.
- R10: `eng_valid` stays high, with op and byte unchanged, until `eng_ready` is seen. After an operation is accepted, no further operation starts until `eng_done` has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fmt | input | 2 | Bit 0: 16-bit address; bit 1: 16-bit data |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 no device, 2 invalid argument, 3 unsupported |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| eng_valid | output | 1 | Engine operation request |
| eng_ready | input | 1 | Engine accepts the operation |
| eng_op | output | 2 | 0 select, 1 write byte, 2 read byte |
| eng_wbyte | output | 8 | Byte to send (meaningful for op 1) |
| eng_done | input | 1 | Engine operation finished |
| eng_ok | input | 1 | Select succeeded (sampled with eng_done) |
| eng_rbyte | input | 8 | Received byte (sampled with eng_done) |

## Verification
The embedded properties check every cycle that the engine handshake holds: the request is held until accepted, and only one operation is outstanding at a time. They also check that the done pulse lasts a single cycle, that a failed select leads straight to a no-device response, that an unsupported format or an out-of-range address answers immediately, and that 8-bit reads clear the upper data byte. The exact byte order on the engine side can only be shown by the bench's scenarios, which sweep every format, both directions, addresses on each side of the range limits and a present or absent slave. These are the command codes, the address and data byte counts, little-endian placement and the read data assembly.

// File: rtl/onewire_reg_seq_pkg.sv
package onewire_reg_seq_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int STEP_W  = 3;

  localparam logic [BYTE_W-1:0] CMD_READ  = 8'h69;
  localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h6C;

  typedef enum logic [1:0] {
    OP_SELECT = 2'd0,
    OP_SEND   = 2'd1,
    OP_RECV   = 2'd2
  } eng_op_e;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_NODEV  = 2'd1,
    ST_BADARG = 2'd2,
    ST_UNSUP  = 2'd3
  } status_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_RESP  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/onewire_reg_req_check.sv
module onewire_reg_req_check
  import onewire_reg_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [1:0]        fmt,
  input  logic [ADDR_W-1:0] addr,
  output status_e           verdict
);
  localparam int EXT_W = ADDR_W + WORD_W + 1;

  logic [EXT_W-1:0] addr_ext;
  logic             over8;
  logic             over16;

  always_comb begin
    addr_ext = EXT_W'(addr);
    over8    = |addr_ext[EXT_W-1:BYTE_W];
    over16   = |addr_ext[EXT_W-1:WORD_W];
  end

  // Unsupported format wins over the range check.
  always_comb begin
    if (fmt == 2'b01) begin
      verdict = ST_UNSUP;
    end else if (fmt[0] ? over16 : over8) begin
      verdict = ST_BADARG;
    end else begin
      verdict = ST_OK;
    end
  end

endmodule

// File: rtl/onewire_reg_step_plan.sv
module onewire_reg_step_plan
  import onewire_reg_seq_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic              is_write,
  input  logic              wide_addr,
  input  logic              wide_data,
  input  logic [WORD_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output eng_op_e           op,
  output logic [BYTE_W-1:0] byte_out,
  output logic              last
);
  localparam logic [STEP_W-1:0] STEP_CMD  = STEP_W'(1);
  localparam logic [STEP_W-1:0] STEP_ADR0 = STEP_W'(2);

  logic [STEP_W-1:0] n_addr;
  logic [STEP_W-1:0] n_data;
  logic [STEP_W-1:0] data_base;
  logic [STEP_W-1:0] final_step;
  logic [STEP_W-1:0] addr_k;
  logic [STEP_W-1:0] data_k;

  always_comb begin
    n_addr     = wide_addr ? STEP_W'(2) : STEP_W'(1);
    n_data     = wide_data ? STEP_W'(2) : STEP_W'(1);
    data_base  = STEP_ADR0 + n_addr;
    final_step = data_base + n_data - STEP_W'(1);
    addr_k     = step - STEP_ADR0;
    data_k     = step - data_base;
  end

  always_comb begin
    op       = OP_SEND;
    byte_out = '0;
    if (step == '0) begin
      op = OP_SELECT;
    end else if (step == STEP_CMD) begin
      byte_out = is_write ? CMD_WRITE : CMD_READ;
    end else if (step < data_base) begin
      byte_out = addr_k[0] ? addr[WORD_W-1:BYTE_W] : addr[BYTE_W-1:0];
    end else if (is_write) begin
      byte_out = data_k[0] ? wdata[WORD_W-1:BYTE_W] : wdata[BYTE_W-1:0];
    end else begin
      op = OP_RECV;
    end
    last = (step == final_step);
  end

endmodule

// File: rtl/onewire_reg_rdata_asm.sv
module onewire_reg_rdata_asm
  import onewire_reg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              upper,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;
  logic              lo_en;
  logic              hi_en;
  logic [BYTE_W-1:0] lo_d;
  logic [BYTE_W-1:0] hi_d;

  always_comb begin
    lo_en = clear | (capture & ~upper);
    hi_en = clear | (capture &  upper);
    lo_d  = clear ? '0 : byte_in;
    hi_d  = clear ? '0 : byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  assign word = {hi_q, lo_q};

endmodule

// File: rtl/onewire_reg_sequencer.sv
module onewire_reg_sequencer
  import onewire_reg_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_fmt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic [1:0]        rsp_status,
  output logic [15:0]       rsp_rdata,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_wbyte,
  input  logic              eng_done,
  input  logic              eng_ok,
  input  logic [7:0]        eng_rbyte
);
  localparam int ADR_KEEP = (ADDR_W < WORD_W) ? ADDR_W : WORD_W;

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  status_e           status_q, status_d;
  logic              write_q;
  logic [1:0]        fmt_q;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              load;
  logic              rd_clear;
  logic              rd_capture;

  status_e           chk_verdict;
  eng_op_e           plan_op;
  logic [BYTE_W-1:0] plan_byte;
  logic              plan_last;
  logic [STEP_W-1:0] data_first;

  onewire_reg_req_check #(.ADDR_W(ADDR_W)) u_check (
    .fmt     (req_fmt),
    .addr    (req_addr),
    .verdict (chk_verdict)
  );

  onewire_reg_step_plan u_plan (
    .step      (step_q),
    .is_write  (write_q),
    .wide_addr (fmt_q[0]),
    .wide_data (fmt_q[1]),
    .addr      (addr_q),
    .wdata     (wdata_q),
    .op        (plan_op),
    .byte_out  (plan_byte),
    .last      (plan_last)
  );

  // First data step index: select + command + address bytes.
  assign data_first = fmt_q[0] ? STEP_W'(4) : STEP_W'(3);

  onewire_reg_rdata_asm u_rdata (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (rd_clear),
    .capture (rd_capture),
    .upper   (step_q != data_first),
    .byte_in (eng_rbyte),
    .word    (rsp_rdata)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    status_d   = status_q;
    load       = 1'b0;
    rd_clear   = 1'b0;
    rd_capture = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (req_valid) begin
          load     = 1'b1;
          rd_clear = 1'b1;
          step_d   = '0;
          status_d = chk_verdict;
          state_d  = (chk_verdict == ST_OK) ? SQ_ISSUE : SQ_RESP;
        end
      end
      SQ_ISSUE: begin
        if (eng_ready) begin
          state_d = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (eng_done) begin
          if (plan_op == OP_SELECT && !eng_ok) begin
            status_d = ST_NODEV;
            state_d  = SQ_RESP;
          end else begin
            rd_capture = (plan_op == OP_RECV);
            if (plan_last) begin
              state_d = SQ_RESP;
            end else begin
              step_d  = step_q + STEP_W'(1);
              state_d = SQ_ISSUE;
            end
          end
        end
      end
      default: begin
        state_d = SQ_IDLE;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      step_q   <= '0;
      status_q <= ST_OK;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      status_q <= status_d;
    end
  end

  // Request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      fmt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      write_q <= req_write;
      fmt_q   <= req_fmt;
      addr_q  <= WORD_W'(req_addr[ADR_KEEP-1:0]);
      wdata_q <= req_wdata;
    end
  end

  assign req_ready  = (state_q == SQ_IDLE);
  assign rsp_done   = (state_q == SQ_RESP);
  assign rsp_status = status_q;
  assign eng_valid  = (state_q == SQ_ISSUE);
  assign eng_op     = plan_op;
  assign eng_wbyte  = plan_byte;

  // ---------------- assertions ----------------
  assert_valid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_ready |=> eng_valid && $stable(eng_op) && $stable(eng_wbyte));

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && eng_ready |=> !eng_valid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done && req_ready);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !eng_valid && !rsp_done);

  assert_select_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_fmt != 2'b01 &&
    req_addr <= (req_fmt[0] ? ADDR_W'(65535) : ADDR_W'(255))
    |=> eng_valid && eng_op == 2'd0);

  assert_select_abort_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SQ_WAIT && eng_done && eng_op == 2'd0 && !eng_ok
    |=> rsp_done && rsp_status == 2'd1);

  assert_unsupported_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_fmt == 2'b01 |=> rsp_done && rsp_status == 2'd3);

  assert_out_of_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_fmt != 2'b01 &&
    req_addr > (req_fmt[0] ? ADDR_W'(65535) : ADDR_W'(255))
    |=> rsp_done && rsp_status == 2'd2);

  assert_narrow_read_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && !fmt_q[1] |-> rsp_rdata[15:8] == 8'h00);

endmodule

// File: tb/onewire_reg_sequencer_bench.sv
`timescale 1ns/1ps
module onewire_reg_sequencer_bench;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic              req_write;
  logic [1:0]        req_fmt;
  logic [ADDR_W-1:0] req_addr;
  logic [15:0]       req_wdata;
  logic              rsp_done;
  logic [1:0]        rsp_status;
  logic [15:0]       rsp_rdata;
  logic              eng_valid;
  logic              eng_ready;
  logic [1:0]        eng_op;
  logic [7:0]        eng_wbyte;
  logic              eng_done;
  logic              eng_ok;
  logic [7:0]        eng_rbyte;

  always #2.5 clk = ~clk;

  onewire_reg_sequencer #(.ADDR_W(ADDR_W)) u_onewire_reg_sequencer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_fmt(req_fmt), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_op(eng_op),
    .eng_wbyte(eng_wbyte), .eng_done(eng_done), .eng_ok(eng_ok),
    .eng_rbyte(eng_rbyte)
  );

  int vectors = 0;
  int miscompares = 0;

  // slave/engine model state
  logic       present;
  logic [7:0] seed;
  int         rd_k;
  int         log_n;
  int         log_op [16];
  int         log_byte [16];
  int         dly_a = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Byte-level engine model
  initial begin
    eng_ready = 1'b0;
    eng_done  = 1'b0;
    eng_ok    = 1'b0;
    eng_rbyte = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n && eng_valid) begin
        int cop;
        repeat (dly_a) @(negedge clk);
        dly_a = (dly_a + 1) % 3;
        cop = int'(eng_op);
        if (log_n < 16) begin
          log_op[log_n]   = cop;
          log_byte[log_n] = int'(eng_wbyte);
        end
        log_n++;
        eng_ready = 1'b1;
        @(negedge clk);
        eng_ready = 1'b0;
        repeat (log_n % 2) @(negedge clk);
        eng_done  = 1'b1;
        eng_ok    = (cop == 0) ? present : 1'b1;
        eng_rbyte = (cop == 2) ? 8'(seed + 8'(rd_k) * 8'h47) : 8'hEE;
        if (cop == 2) rd_k++;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  task automatic run_txn(input bit wr, input logic [1:0] fmt,
                         input logic [ADDR_W-1:0] addr, input logic [15:0] wd,
                         input bit pres, input int n);
    int exp_status;
    int exp_n;
    int exp_op [16];
    int exp_byte [16];
    int t;
    int nd;
    string tag;
    logic [15:0] exp_rd;

    present = pres;
    seed    = 8'(8'h21 + 8'(n) * 8'h0B);
    rd_k    = 0;
    log_n   = 0;

    t = 0;
    do begin @(negedge clk); t++; end while (!req_ready && t < 500);
    req_valid = 1'b1; req_write = wr; req_fmt = fmt;
    req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_done && t < 500) begin @(negedge clk); t++; end

    // expected behaviour from the requirements
    nd = fmt[1] ? 2 : 1;
    exp_n = 0;
    if (fmt == 2'b01) exp_status = 3;
    else if (addr > (fmt[0] ? 65535 : 255)) exp_status = 2;
    else if (!pres) exp_status = 1;
    else exp_status = 0;
    if (exp_status == 0 || exp_status == 1) begin
      exp_op[0] = 0; exp_byte[0] = 0; exp_n = 1;
    end
    if (exp_status == 0) begin
      exp_op[1] = 1; exp_byte[1] = wr ? 'h6C : 'h69;
      exp_op[2] = 1; exp_byte[2] = int'(addr[7:0]);
      exp_n = 3;
      if (fmt[0]) begin exp_op[3] = 1; exp_byte[3] = int'(addr[15:8]); exp_n = 4; end
      for (int k = 0; k < nd; k++) begin
        exp_op[exp_n]   = wr ? 1 : 2;
        exp_byte[exp_n] = (k == 0) ? int'(wd[7:0]) : int'(wd[15:8]);
        exp_n++;
      end
    end

    case (exp_status)
      1: tag = "R1";
      2: tag = "R7";
      3: tag = "R8";
      default: tag = "R9";
    endcase
    check(rsp_done === 1'b1, "R9", "done pulse seen", int'(rsp_done), 1);
    check(int'(rsp_status) == exp_status, tag, "status", int'(rsp_status), exp_status);
    check(log_n == exp_n, (exp_status >= 2) ? tag : (fmt[0] ? "R5" : "R6"),
          "engine op count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      if (i == 0) tag = "R1";
      else if (i == 1) tag = wr ? "R3" : "R2";
      else if (i < (fmt[0] ? 4 : 3)) tag = "R5";
      else tag = "R4";
      check(log_op[i] == exp_op[i], tag, "engine op", log_op[i], exp_op[i]);
      if (exp_op[i] == 1)
        check(log_byte[i] == exp_byte[i], tag, "engine byte", log_byte[i], exp_byte[i]);
    end
    if (!wr && exp_status == 0) begin
      exp_rd = fmt[1] ? {8'(seed + 8'h47), seed} : {8'h00, seed};
      check(rsp_rdata == exp_rd, fmt[1] ? "R4" : "R6", "read data",
            int'(rsp_rdata), int'(exp_rd));
    end
    @(negedge clk);
    check(!rsp_done && req_ready, "R9", "single-cycle done, idle after",
          int'({rsp_done, req_ready}), 1);
  endtask

  initial begin
    logic [ADDR_W-1:0] addrs [7];
    int n;
    addrs[0] = 24'h000000; addrs[1] = 24'h0000A5; addrs[2] = 24'h0000FF;
    addrs[3] = 24'h000100; addrs[4] = 24'h00C3E1; addrs[5] = 24'h00FFFF;
    addrs[6] = 24'h010000;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_fmt = '0;
    req_addr = '0; req_wdata = '0; present = 1'b1; seed = 8'h00;
    rd_k = 0; log_n = 0;
    repeat (4) @(negedge clk);
    check(req_ready === 1'b1 && eng_valid === 1'b0 && rsp_done === 1'b0,
          "R9", "reset state", int'({req_ready, eng_valid, rsp_done}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    n = 0;
    for (int f = 0; f < 4; f++)
      for (int w = 0; w < 2; w++)
        for (int a = 0; a < 7; a++)
          for (int p = 1; p >= 0; p--) begin
            run_txn(w[0], f[1:0], addrs[a], 16'(16'hB4D2 + n * 16'h0137), p[0], n);
            n++;
          end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule